// File: doc/BRIEF.md
# Soft Shutdown Volume Ramp Controller

This block is placed between the host's control bits and the output gain stage of a DSP core. When the host raises the shutdown request, the block fades the output gain toward zero. It advances one step on each audio sample strobe. It halts the core once the gain reaches zero or once a fixed timeout, counted in sample strobes, runs out, whichever comes first. While the core is halted, host memory accesses pass through to the program and parameter memories. A burst access takes one start address and then steps the address after every word.

Dropping the request restarts the core in the next cycle and fades the gain back up to full scale. A ramp-speed select chooses a large or a small step. With the small step, the timeout can expire while the gain is still above zero, and the core halts at that point anyway. A request that changes direction mid-fade reverses from the present gain value. The gain never jumps.

Top module: `ss_shutdown_ctrl`

## Requirements
- R1: After reset, gain_o is full scale (2^GAIN_W-1), core_run_o is 1 and halted_o is 0.
- R2: While shutdown_req_i is held and the core is not halted, gain_o never rises, and each sample strobe lowers it by the selected step, saturating at 0.
- R3: With the fast step, the core halts (core_run_o=0, halted_o=1) in the cycle after gain_o reaches 0.
- R4: With the slow step (slow_ramp_i=1), the core halts after TIMEOUT_TICKS strobes even though gain_o is not 0, and gain_o then holds steady while halted.
- R5: Ramp progress and the timeout advance only on sample strobes. Without strobes, gain_o and the run state are unchanged.
- R6: mem_we_o and mem_re_o are 0, and mem_wdata_o is 0, whenever halted_o is 0. Address loads are then ignored.
- R7: While halted, host_addr_load_i sets mem_addr_o to host_addr_i, and every accepted read or write advances mem_addr_o by one on the next cycle.
- R8: In the cycle after shutdown_req_i is seen low, halted_o is 0 and core_run_o is 1. gain_o then rises by the step per strobe, saturating at full scale.
- R9: Asserting shutdown_req_i during a ramp-up makes gain_o fall from its current value, without any jump.
- R10: Releasing shutdown_req_i during a ramp-down returns gain_o to full scale without halting the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_tick_i | input | 1 | One-cycle audio sample strobe |
| shutdown_req_i | input | 1 | Host shutdown request level |
| slow_ramp_i | input | 1 | 1 selects the slow step |
| host_addr_load_i | input | 1 | Load a burst start address |
| host_addr_i | input | ADDR_W | Burst start address |
| host_wr_i | input | 1 | Host write of one word |
| host_rd_i | input | 1 | Host read of one word |
| host_wdata_i | input | DATA_W | Host write data |
| gain_o | output | GAIN_W | Gain multiplier for the output stage |
| core_run_o | output | 1 | Core execution enable |
| halted_o | output | 1 | Shutdown complete flag |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |

## Verification
On every cycle, the assertions check four things: that memory strobes stay closed while the core runs, that the gain never rises under a held request, that the gain changes only on a strobe and stays frozen while halted, and that a released request always clears the halt. Other behaviours need the bench's scenarios and its reference model. These are: the exact halt point (gain reaching zero on the fast step, timeout expiry on the slow step), the burst address sequence, and the reversals in both directions.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_DOWN = 2'd1,
    ST_HALT = 2'd2
  } ss_state_e;
endpackage

// File: rtl/ss_gain_ramp.sv
module ss_gain_ramp #(
  parameter int GAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              up_en_i,
  input  logic              dn_en_i,
  input  logic [GAIN_W-1:0] step_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam logic [GAIN_W-1:0] GainMax = {GAIN_W{1'b1}};

  logic [GAIN_W:0] sum;
  logic [GAIN_W:0] diff;

  assign sum  = {1'b0, gain_o} + {1'b0, step_i};
  assign diff = {1'b0, gain_o} - {1'b0, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o <= GainMax;
    end else if (tick_i) begin
      if (up_en_i)      gain_o <= sum[GAIN_W]  ? GainMax : sum[GAIN_W-1:0];
      else if (dn_en_i) gain_o <= diff[GAIN_W] ? '0      : diff[GAIN_W-1:0];
    end
  end
endmodule

// File: rtl/ss_timeout.sv
module ss_timeout #(
  parameter int TIMEOUT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic count_i,
  output logic expired_o
);
  localparam int CntW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CntW-1:0] Limit = CntW'(TIMEOUT_TICKS);

  logic [CntW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt <= '0;
    else if (clear_i)                 cnt <= '0;
    else if (count_i && cnt != Limit) cnt <= cnt + 1'b1;
  end

  assign expired_o = (cnt == Limit);
endmodule

// File: rtl/ss_host_gate.sv
module ss_host_gate #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              allow_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        addr_q <= '0;
    else if (allow_i && addr_load_i)    addr_q <= addr_i;
    else if (allow_i && (wr_i || rd_i)) addr_q <= addr_q + 1'b1;
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = allow_i & wr_i;
  assign mem_re_o    = allow_i & rd_i;
  assign mem_wdata_o = allow_i ? wdata_i : '0;
endmodule

// File: rtl/ss_shutdown_ctrl.sv
module ss_shutdown_ctrl
  import ss_pkg::*;
#(
  parameter int GAIN_W        = 12,
  parameter int FAST_STEP     = 512,
  parameter int SLOW_STEP     = 128,
  parameter int TIMEOUT_TICKS = 16,
  parameter int ADDR_W        = 10,
  parameter int DATA_W        = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_tick_i,
  input  logic              shutdown_req_i,
  input  logic              slow_ramp_i,
  input  logic              host_addr_load_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic              core_run_o,
  output logic              halted_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam logic [GAIN_W-1:0] StepFast = GAIN_W'(FAST_STEP);
  localparam logic [GAIN_W-1:0] StepSlow = GAIN_W'(SLOW_STEP);

  ss_state_e state_q, state_d;
  logic      expired;
  logic      halt_now;
  logic      up_en, dn_en;
  logic [GAIN_W-1:0] step;

  assign step     = slow_ramp_i ? StepSlow : StepFast;
  assign halt_now = (gain_o == '0) || expired;
  assign up_en    = (state_q == ST_RUN) && !shutdown_req_i;
  assign dn_en    = (state_q == ST_DOWN) && shutdown_req_i && !halt_now;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (shutdown_req_i) state_d = ST_DOWN;
      ST_DOWN: begin
        if (!shutdown_req_i) state_d = ST_RUN;
        else if (halt_now)   state_d = ST_HALT;
      end
      ST_HALT: if (!shutdown_req_i) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign core_run_o = (state_q != ST_HALT);
  assign halted_o   = (state_q == ST_HALT);

  ss_gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (sample_tick_i),
    .up_en_i (up_en),
    .dn_en_i (dn_en),
    .step_i  (step),
    .gain_o  (gain_o)
  );

  ss_timeout #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (state_q != ST_DOWN),
    .count_i   (dn_en && sample_tick_i),
    .expired_o (expired)
  );

  ss_host_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .allow_i     (halted_o),
    .addr_load_i (host_addr_load_i),
    .addr_i      (host_addr_i),
    .wr_i        (host_wr_i),
    .rd_i        (host_rd_i),
    .wdata_i     (host_wdata_i),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );
endmodule

// File: rtl/ss_shutdown_chk.sv
module ss_shutdown_chk #(
  parameter int GAIN_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_tick_i,
  input logic              shutdown_req_i,
  input logic [GAIN_W-1:0] gain_o,
  input logic              halted_o,
  input logic              mem_we_o,
  input logic              mem_re_o
);
  assert_gate_closed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> (!mem_we_o && !mem_re_o));

  assert_no_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(shutdown_req_i) |-> (gain_o <= $past(gain_o)));

  assert_tick_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_o != $past(gain_o)) |-> $past(sample_tick_i));

  assert_hold_halted_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && $past(halted_o)) |-> $stable(gain_o));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(shutdown_req_i) |-> !halted_o);
endmodule

bind ss_shutdown_ctrl ss_shutdown_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_tick_i  (sample_tick_i),
  .shutdown_req_i (shutdown_req_i),
  .gain_o         (gain_o),
  .halted_o       (halted_o),
  .mem_we_o       (mem_we_o),
  .mem_re_o       (mem_re_o)
);

// File: tb/tb_ss_shutdown_ctrl.sv
`timescale 1ns/1ps
module tb_ss_shutdown_ctrl;
  localparam int GW = 12, AW = 10, DW = 32;
  localparam int FAST = 512, SLOW = 128, TMO = 16;
  localparam int GMAX = (1 << GW) - 1;

  logic clk = 0, rst_n = 0;
  logic tick = 0, req = 0, slow = 0, ld = 0, wr = 0, rd = 0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hdata = '0;
  logic [GW-1:0] gain;
  logic run, halted, we, re;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mdata;

  int checks = 0, errors = 0, cyc = 0;
  bit tick_en = 1, cmp_on = 0, done = 0;
  string tag = "R1";

  int m_st = 0, m_gain = GMAX, m_tmr = 0, m_addr = 0;

  always #5 clk = ~clk;

  ss_shutdown_ctrl #(.GAIN_W(GW), .FAST_STEP(FAST), .SLOW_STEP(SLOW),
    .TIMEOUT_TICKS(TMO), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_tick_i(tick), .shutdown_req_i(req),
    .slow_ramp_i(slow), .host_addr_load_i(ld), .host_addr_i(haddr),
    .host_wr_i(wr), .host_rd_i(rd), .host_wdata_i(hdata),
    .gain_o(gain), .core_run_o(run), .halted_o(halted), .mem_we_o(we),
    .mem_re_o(re), .mem_addr_o(maddr), .mem_wdata_o(mdata));

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", r, $time, act, exp);
    end
  endtask

  // reference model: 0 run, 1 fading down, 2 halted
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_gain = GMAX; m_tmr = 0; m_addr = 0;
    end else begin
      int stp;
      stp = slow ? SLOW : FAST;
      if (m_st == 2) begin
        if (ld) m_addr = haddr;
        else if (wr || rd) m_addr = (m_addr + 1) % (1 << AW);
      end
      case (m_st)
        0: if (req) begin m_st = 1; m_tmr = 0; end
           else if (tick) m_gain = (m_gain + stp > GMAX) ? GMAX : m_gain + stp;
        1: if (!req) m_st = 0;
           else if (m_gain == 0 || m_tmr == TMO) m_st = 2;
           else if (tick) begin
             m_gain = (m_gain < stp) ? 0 : m_gain - stp;
             m_tmr++;
           end
        default: if (!req) m_st = 0;
      endcase
    end
  end

  always begin
    @(posedge clk); #2;
    cyc++;
    tick = tick_en && (cyc % 4 == 0);
  end

  always begin
    @(posedge clk); #7;
    if (cmp_on) begin
      chk(tag, gain, m_gain);
      chk(tag, run, m_st != 2);
      chk(tag, halted, m_st == 2);
      chk({tag, "_R6"}, we, (m_st == 2) && wr);
      chk({tag, "_R6"}, re, (m_st == 2) && rd);
      chk(tag, mdata, (m_st == 2) ? int'(hdata) : 0);
      chk(tag, maddr, m_addr);
    end
  end

  task automatic step_n(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_halt(int lim);
    for (int i = 0; i < lim && !halted; i++) step_n(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step_n(5);
    rst_n = 1;
    #5;
    chk("R1", gain, GMAX); chk("R1", run, 1); chk("R1", halted, 0);
    step_n(1);
    cmp_on = 1;
    step_n(10);

    tag = "R6"; ld = 1; haddr = 10'd77; wr = 1; hdata = 32'hABCD;
    #5; chk("R6", we, 0); chk("R6", mdata, 0);
    step_n(1); ld = 0; wr = 0; rd = 1;
    #5; chk("R6", re, 0); chk("R6", maddr, 0);
    step_n(1); rd = 0;

    tag = "R5"; tick_en = 0; req = 1;
    step_n(24);
    #5; chk("R5", gain, GMAX); chk("R5", halted, 0);
    step_n(1); tick_en = 1;

    tag = "R2"; step_n(5);
    #5; chk("R2", gain, GMAX - FAST);
    step_n(1);
    tag = "R3"; wait_halt(300);
    #5; chk("R3", gain, 0); chk("R3", run, 0); chk("R3", halted, 1);
    step_n(1);

    tag = "R7"; ld = 1; haddr = 10'd100;
    step_n(1); ld = 0; wr = 1; hdata = 32'h11;
    #5; chk("R7", maddr, 100); chk("R7", we, 1);
    step_n(1); hdata = 32'h22;
    step_n(1); hdata = 32'h33;
    step_n(1); wr = 0; rd = 1;
    step_n(2); rd = 0;
    #5; chk("R7", maddr, 105);
    step_n(1);
    ld = 1; haddr = 10'd1023;
    step_n(1); ld = 0; wr = 1;
    step_n(1); wr = 0;
    #5; chk("R7", maddr, 0);
    step_n(1);

    tag = "R8"; req = 0; wr = 1;
    step_n(1);
    #5; chk("R8", run, 1); chk("R8", halted, 0); chk("R6", we, 0);
    step_n(1); wr = 0;
    step_n(10);
    tag = "R9"; req = 1;
    step_n(1);
    #5; chk("R9", gain, m_gain);
    step_n(8);
    #5; chk("R9", gain, m_gain);
    step_n(1);
    wait_halt(300);
    req = 0; tag = "R8";
    step_n(60);
    #5; chk("R8", gain, GMAX);

    step_n(1);
    tag = "R10"; req = 1;
    step_n(10);
    req = 0;
    step_n(40);
    #5; chk("R10", gain, GMAX); chk("R10", run, 1);

    step_n(1);
    tag = "R4"; slow = 1; req = 1;
    wait_halt(300);
    #5; chk("R4", halted, 1); chk("R4", gain, GMAX - TMO * SLOW);
    step_n(20);
    #5; chk("R4", gain, GMAX - TMO * SLOW);
    step_n(1);
    req = 0; tag = "R8";
    step_n(150);
    #5; chk("R8", gain, GMAX);

    cmp_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule